// File: doc/BRIEF.md
# Zero-Run / One-Run Sequence Detector

This block watches a one-bit serial stream, taking one sample per clock edge whenever a valid strobe is high. It raises a single-cycle pulse when the most recent accepted samples are a run of 15 zeros followed immediately by a run of 17 ones. That is a 32-bit pattern. The block does not keep a 32-bit history. It tracks the pattern with two small saturating run-length counters, one for zeros and one for ones. Control logic drives each counter's enable and clear, and a comparator looks at both counts.

A one followed by a zero ends any candidate run. That zero becomes the first zero of a new candidate. A zero run longer than required still qualifies, because only its last 15 samples belong to the window. Ones count only after the zero count has reached the required length. Both run lengths are parameters.

Top module: `run_len_seq_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `detect` is 0. Reset clears both counters and the stored previous bit.
- R2: 15 accepted zeros followed by 17 accepted ones make `detect` go high right after the clock edge that accepts the 17th one.
- R3: `detect` is high for exactly one cycle per match. A further run of ones after the 17th one does not raise it again.
- R4: A zero run longer than 15 samples, followed by 17 ones, still produces exactly one pulse.
- R5: A zero run of only 14 samples followed by 17 ones produces no pulse.
- R6: 15 zeros followed by only 16 ones and then a zero produce no pulse. The trailing zero starts a new run that can match.
- R7: A one followed by a zero clears both counters. That zero counts as the first zero of the new run, so zeros seen before the restart do not carry over.
- R8: A clock edge with `smp_valid` low accepts no sample, whatever `smp_bit` is. Idle gaps inside a run neither break it nor lengthen it.
- R9: Neither counter wraps. After 300 zeros, 17 ones still match once. After a match, 300 more ones produce no second pulse.
- R10: Ones accepted before the zero count reaches 15 are not counted. For example, 17 ones straight after reset produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | High when `smp_bit` holds a sample to accept |
| smp_bit | input | 1 | Serial data bit |
| detect | output | 1 | One-cycle pulse after the accepting edge of the 17th one of a match |

## Verification
The bench checks both sides of each boundary.
- Run lengths are tried one short of the requirement (14 zeros, 16 ones), exactly at it, and far beyond it. A counter that wraps would miss the 300-zero case or fire again during 300 ones. An off-by-one compare would fire on the short runs.
- Restart is tested with ones between two zero runs. A design that forgot to clear on a one-to-zero transition would add stale zeros and match too early. A design that did not count the restarting zero would need 16 zeros.
- Strobe gaps are interleaved with toggling data. A block that samples while `smp_valid` is low would miscount.
- Leading ones after reset must be ignored, so a one counter that runs without a qualified zero run shows up.

// File: rtl/seq_run_pkg.sv
package seq_run_pkg;

    // Classification of one clock edge by the run controller.
    typedef enum logic [2:0] {
        ACT_IDLE      = 3'd0,  // no accepted sample
        ACT_ZERO_MORE = 3'd1,  // zero extending the current zero run
        ACT_RESTART   = 3'd2,  // zero after a one: new candidate run
        ACT_ONE_MORE  = 3'd3,  // one extending a qualified ones run
        ACT_ONE_STRAY = 3'd4   // one arriving before the zero run qualifies
    } run_act_e;

    // Control bundle for one saturating run counter.
    typedef struct packed {
        logic clr;
        logic en;
    } cnt_ctrl_t;

endpackage

// File: rtl/rl_sat_counter.sv
module rl_sat_counter #(
    parameter int LIMIT = 16,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         en_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] count_d, count_q;

    // clr with en loads 1: the current sample is the first of a new run.
    always_comb begin
        count_d = count_q;
        if (clr_i) begin
            count_d = en_i ? W'(1) : '0;
        end else if (en_i && (count_q != LIM)) begin
            count_d = count_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count_o = count_q;

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count_q <= LIM);                                           // R9
    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i && count_q == LIM) |=> (count_q == LIM));  // R9
    AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(count_q));                   // R8

endmodule

// File: rtl/rl_run_ctrl.sv
module rl_run_ctrl
    import seq_run_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      smp_valid_i,
    input  logic      smp_bit_i,
    input  logic      zero_ok_i,
    output cnt_ctrl_t zero_ctl_o,
    output cnt_ctrl_t one_ctl_o
);
    typedef struct packed {
        logic prev_one;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    run_act_e    act;

    always_comb begin
        st_d = st_q;
        act  = ACT_IDLE;
        if (smp_valid_i) begin
            st_d.prev_one = smp_bit_i;
            if (!smp_bit_i) act = st_q.prev_one ? ACT_RESTART : ACT_ZERO_MORE;
            else            act = zero_ok_i ? ACT_ONE_MORE : ACT_ONE_STRAY;
        end
    end

    always_comb begin
        zero_ctl_o = '0;
        one_ctl_o  = '0;
        unique case (act)
            ACT_ZERO_MORE: zero_ctl_o.en = 1'b1;
            ACT_RESTART: begin
                zero_ctl_o.clr = 1'b1;
                zero_ctl_o.en  = 1'b1;
                one_ctl_o.clr  = 1'b1;
            end
            ACT_ONE_MORE:  one_ctl_o.en = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_ONE_NEEDS_ZEROS: assert property (@(posedge clk) disable iff (rst)
        one_ctl_o.en |-> zero_ok_i);                               // R10
    AST_NO_ACTION_IDLE: assert property (@(posedge clk) disable iff (rst)
        !smp_valid_i |-> (zero_ctl_o == '0 && one_ctl_o == '0));   // R8

endmodule

// File: rtl/rl_match.sv
module rl_match #(
    parameter int ZERO_RUN = 15,
    parameter int ONE_RUN  = 17,
    localparam int ZW = $clog2(ZERO_RUN + 2),
    localparam int OW = $clog2(ONE_RUN + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid_i,
    input  logic          smp_bit_i,
    input  logic [ZW-1:0] zero_cnt_i,
    input  logic [OW-1:0] one_cnt_i,
    output logic          zero_ok_o,
    output logic          detect_o
);
    localparam logic [ZW-1:0] ZERO_REQ  = ZW'(ZERO_RUN);
    localparam logic [OW-1:0] ONE_FINAL = OW'(ONE_RUN - 1);

    typedef struct packed {
        logic detect;
    } match_state_t;

    match_state_t st_d, st_q;

    assign zero_ok_o = (zero_cnt_i >= ZERO_REQ);

    // Fires on the sample that moves the one count to ONE_RUN.
    always_comb begin
        st_d.detect = smp_valid_i && smp_bit_i && zero_ok_o &&
                      (one_cnt_i == ONE_FINAL);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign detect_o = st_q.detect;

endmodule

// File: rtl/run_len_seq_detector.sv
module run_len_seq_detector
    import seq_run_pkg::*;
#(
    parameter int ZERO_RUN = 15,
    parameter int ONE_RUN  = 17
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic smp_bit,
    output logic detect
);
    localparam int ZLIM = ZERO_RUN + 1;
    localparam int OLIM = ONE_RUN + 1;
    localparam int ZW   = $clog2(ZLIM + 1);
    localparam int OW   = $clog2(OLIM + 1);
    localparam logic [ZW-1:0] ZERO_REQ = ZW'(ZERO_RUN);
    localparam logic [OW-1:0] ONE_REQ  = OW'(ONE_RUN);

    cnt_ctrl_t     zero_ctl, one_ctl;
    logic [ZW-1:0] zero_cnt;
    logic [OW-1:0] one_cnt;
    logic          zero_ok;

    rl_run_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .smp_valid_i (smp_valid),
        .smp_bit_i   (smp_bit),
        .zero_ok_i   (zero_ok),
        .zero_ctl_o  (zero_ctl),
        .one_ctl_o   (one_ctl)
    );

    rl_sat_counter #(.LIMIT(ZLIM)) u_zero_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (zero_ctl.clr),
        .en_i    (zero_ctl.en),
        .count_o (zero_cnt)
    );

    rl_sat_counter #(.LIMIT(OLIM)) u_one_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (one_ctl.clr),
        .en_i    (one_ctl.en),
        .count_o (one_cnt)
    );

    rl_match #(.ZERO_RUN(ZERO_RUN), .ONE_RUN(ONE_RUN)) u_match (
        .clk         (clk),
        .rst         (rst),
        .smp_valid_i (smp_valid),
        .smp_bit_i   (smp_bit),
        .zero_cnt_i  (zero_cnt),
        .one_cnt_i   (one_cnt),
        .zero_ok_o   (zero_ok),
        .detect_o    (detect)
    );

    AST_DET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        detect |=> !detect);                                          // R3
    AST_DET_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        detect |-> (zero_cnt >= ZERO_REQ && one_cnt == ONE_REQ));     // R2
    AST_ONES_AFTER_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (one_cnt != '0) |-> (zero_cnt >= ZERO_REQ));                  // R10
    AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_bit && one_cnt != '0) |=>
        (zero_cnt == ZW'(1) && one_cnt == '0));                       // R7

endmodule

// File: tb/run_len_seq_detector_bench.sv
`timescale 1ns/1ps
module run_len_seq_detector_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic smp_bit = 1'b0;
    logic detect;

    int n_checks = 0;
    int n_fails  = 0;
    int sample_idx = 0;
    int pulses = 0;
    int last_pulse = 0;

    always #2.5 clk = ~clk;

    run_len_seq_detector u_run_len_seq_detector (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit),
        .detect    (detect)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic do_reset();
        rst = 1'b1; smp_valid = 1'b0; smp_bit = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sample_idx = 0; pulses = 0; last_pulse = 0;
    endtask

    task automatic send(input bit b);
        smp_valid = 1'b1; smp_bit = b;
        @(negedge clk);
        sample_idx++;
        if (detect) begin pulses++; last_pulse = sample_idx; end
    endtask

    task automatic send_run(input bit b, input int n);
        for (int i = 0; i < n; i++) send(b);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            smp_valid = 1'b0; smp_bit = i[0];
            @(negedge clk);
            if (detect) begin pulses++; last_pulse = -1; end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; smp_valid = 1'b1; smp_bit = 1'b1;
        @(negedge clk); @(negedge clk);
        check(detect == 1'b0, "R1 detect during reset", detect, 0);
        rst = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        check(detect == 1'b0, "R1 detect after reset", detect, 0);
    endtask

    task automatic t_basic();
        do_reset();
        send_run(1'b0, 15); send_run(1'b1, 17);
        check(pulses == 1, "R2 pulse count", pulses, 1);
        check(last_pulse == 32, "R2 pulse sample", last_pulse, 32);
        gap(1);
        check(detect == 1'b0, "R3 pulse width", detect, 0);
    endtask

    task automatic t_extra_ones();
        do_reset();
        send_run(1'b0, 15); send_run(1'b1, 25);
        check(pulses == 1, "R3 extra ones pulse count", pulses, 1);
        check(last_pulse == 32, "R3 pulse sample", last_pulse, 32);
    endtask

    task automatic t_long_zero();
        do_reset();
        send_run(1'b0, 22); send_run(1'b1, 17);
        check(pulses == 1 && last_pulse == 39, "R4 longer zero run", last_pulse, 39);
        do_reset();
        send_run(1'b0, 300); send_run(1'b1, 17);
        check(pulses == 1 && last_pulse == 317, "R9 300 zeros no wrap", last_pulse, 317);
    endtask

    task automatic t_short_zero();
        do_reset();
        send_run(1'b0, 14); send_run(1'b1, 17);
        check(pulses == 0, "R5 14 zeros", pulses, 0);
    endtask

    task automatic t_short_one();
        do_reset();
        send_run(1'b0, 15); send_run(1'b1, 16);
        check(pulses == 0, "R6 16 ones", pulses, 0);
        send_run(1'b0, 15); send_run(1'b1, 17);
        check(pulses == 1 && last_pulse == 63, "R6 rerun after short ones", last_pulse, 63);
    endtask

    task automatic t_restart();
        do_reset();
        send_run(1'b0, 20); send_run(1'b1, 5);
        send_run(1'b0, 15); send_run(1'b1, 17);
        check(pulses == 1 && last_pulse == 57, "R7 restart counts first zero", last_pulse, 57);
        do_reset();
        send_run(1'b0, 10); send_run(1'b1, 3);
        send_run(1'b0, 14); send_run(1'b1, 17);
        check(pulses == 0, "R7 stale zeros discarded", pulses, 0);
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 15; i++) begin send(1'b0); if (i % 3 == 0) gap(2); end
        for (int i = 0; i < 17; i++) begin send(1'b1); if (i % 4 == 1) gap(3); end
        check(pulses == 1 && last_pulse == 32, "R8 gaps ignored", last_pulse, 32);
        do_reset();
        send_run(1'b0, 14); gap(5); send_run(1'b1, 17);
        check(pulses == 0, "R8 idle zeros not counted", pulses, 0);
    endtask

    task automatic t_long_ones();
        do_reset();
        send_run(1'b0, 15); send_run(1'b1, 300);
        check(pulses == 1 && last_pulse == 32, "R9 300 ones single pulse", pulses, 1);
    endtask

    task automatic t_lead_ones();
        do_reset();
        send_run(1'b1, 17);
        check(pulses == 0, "R10 leading ones", pulses, 0);
        send_run(1'b0, 15); send_run(1'b1, 17);
        check(pulses == 1 && last_pulse == 49, "R10 match after leading ones", last_pulse, 49);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_extra_ones();
        t_long_zero();
        t_short_zero();
        t_short_one();
        t_restart();
        t_gaps();
        t_long_ones();
        t_lead_ones();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule